// File: doc/BRIEF.md
# Dual-Bank Programmable Interrupt Controller

This block collects 64 interrupt inputs and turns them into two processor request lines, a normal request and a fast request. Every source has its own settings. A detection type picks level-sensitive or edge-latched behaviour. A polarity picks active-high/rising or active-low/falling. A route bit picks which of the two outputs the source feeds. An enable bit lets the source reach its output. Software works through a simple register port with a write strobe, an address and write data. Read data is returned combinationally for the address currently on the port.

The 64 sources are held in two 32-bit banks. Source `n` lives in bank `n / 32` at bit `n % 32`, and the bank-1 copy of each per-source register sits 4 bytes above its bank-0 copy. Enables can be written whole, or changed with write-one-to-set and write-one-to-clear registers. Edge-latched pending bits are acknowledged with a write-one register. A software-request register makes a source pending as if its input were active. A per-output master enable gates each request line. A read-only register returns the number of the lowest pending normal-routed source. When nothing is pending it returns a programmable "none" code instead.

Register offsets (bank 1 = bank 0 + 4): route 0x00, enable 0x10, enable-clear 0x20, enable-set 0x30, type 0x40, polarity 0x50, none code 0x60, master 0x64, normal status 0x80, fast status 0x90, raw status 0xA0, acknowledge 0xB0, software request 0xC0, pending number 0xD0. Write-only registers and unmapped or misaligned addresses read as 0.

Top module: `pic_dual_bank`

## Requirements
- R1: After reset, every route, enable, type, polarity, software-request, master and none-code register reads 0, and both request outputs are low.
- R2: Source n is controlled and reported at bit n%32 of the bank-n/32 register; the bank-1 register is at the bank-0 offset plus 4, so source 63 appears at bit 31 of the 0x?4 registers.
- R3: A write to 0x10/0x14 loads the enables. A write to 0x30/0x34 sets the enable bits written as 1. A write to 0x20/0x24 clears the enable bits written as 1. Bits written as 0 in a set or clear write keep their value.
- R4: A level source (type bit 0) shows as raw-pending (0xA0/0xA4) in the same cycle its input is active: input high when its polarity bit is 0, input low when its polarity bit is 1.
- R5: An edge source (type bit 1) latches pending on the clock edge where its polarity-adjusted input is 1 after being 0 on the previous edge. It then stays pending after the input returns inactive.
- R6: Writing 1 to a bit of 0xB0/0xB4 clears that source's latched edge pending. For a level source with an active input the write has no effect on the raw status.
- R7: Setting a bit in 0xC0/0xC4 makes that source pending as if its input were active. Clearing the bit removes it for a level source.
- R8: The normal status (0x80/0x84) shows enabled pending sources whose route bit is 0. The fast status (0x90/0x94) shows those whose route bit is 1 (route registers 0x00/0x04).
- R9: Master enable bit 0 (0x64) gates the normal request output and bit 1 gates the fast request output. Each output is high exactly when its master bit is 1 and its status has any bit set. The status registers are not affected by the master bits.
- R10: The register at 0xD0 returns the lowest source number set in the normal status, whatever the master bits. When the normal status is empty it returns the value written to 0x60.
- R11: When an edge and an acknowledge of the same source fall on the same clock edge, the source stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | N_SRC | Interrupt inputs, already synchronous to clk |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | DW | Register write data |
| bus_rdata | output | DW | Read data for bus_addr (combinational) |
| irq_out | output | 1 | Normal interrupt request |
| fiq_out | output | 1 | Fast interrupt request |

## Verification
A wrong enable, route or latch bit shows up at the request pins in the same cycle it exists, because the outputs are combinational from state and inputs. The reference model compares both pins and the read data every clock, so a corrupted bit is reported on the first clock after the bad write or edge, provided that source is driven and being read. A lost or extra edge latch stays visible in raw status until it is acknowledged, so it cannot hide between samples. The pending-number readout ties every enabled normal source to a single value, so a priority-order fault appears as a wrong number as soon as two sources are pending together.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int REG_AW = 8;

  localparam logic [REG_AW-1:0] OFS_ROUTE  = 8'h00;
  localparam logic [REG_AW-1:0] OFS_EN     = 8'h10;
  localparam logic [REG_AW-1:0] OFS_ENCLR  = 8'h20;
  localparam logic [REG_AW-1:0] OFS_ENSET  = 8'h30;
  localparam logic [REG_AW-1:0] OFS_TYPE   = 8'h40;
  localparam logic [REG_AW-1:0] OFS_POL    = 8'h50;
  localparam logic [REG_AW-1:0] OFS_NOPEND = 8'h60;
  localparam logic [REG_AW-1:0] OFS_MASTER = 8'h64;
  localparam logic [REG_AW-1:0] OFS_IRQST  = 8'h80;
  localparam logic [REG_AW-1:0] OFS_FIQST  = 8'h90;
  localparam logic [REG_AW-1:0] OFS_RAW    = 8'hA0;
  localparam logic [REG_AW-1:0] OFS_ACK    = 8'hB0;
  localparam logic [REG_AW-1:0] OFS_SOFT   = 8'hC0;
  localparam logic [REG_AW-1:0] OFS_PNUM   = 8'hD0;

  typedef struct packed {
    logic [REG_AW-1:0] base;
    logic [1:0]        bank;
    logic              aligned;
  } addr_split_t;

  // Banked registers repeat every 4 bytes inside a 16-byte group.
  function automatic addr_split_t split_addr(input logic [REG_AW-1:0] a);
    addr_split_t s;
    s.base    = {a[REG_AW-1:4], 4'h0};
    s.bank    = a[3:2];
    s.aligned = (a[1:0] == 2'b00);
    return s;
  endfunction
endpackage

// File: rtl/intc_regs.sv
module intc_regs
  import intc_pkg::*;
#(
  parameter int NB = 2,
  parameter int DW = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_wr,
  input  logic [REG_AW-1:0]      bus_addr,
  input  logic [DW-1:0]          bus_wdata,
  output logic [NB-1:0][DW-1:0]  route_q,
  output logic [NB-1:0][DW-1:0]  en_q,
  output logic [NB-1:0][DW-1:0]  type_q,
  output logic [NB-1:0][DW-1:0]  pol_q,
  output logic [NB-1:0][DW-1:0]  soft_q,
  output logic [NB-1:0][DW-1:0]  ack_pulse,
  output logic [DW-1:0]          nopend_q,
  output logic [1:0]             master_q
);
  addr_split_t sp;
  logic        wr_ok;

  assign sp    = split_addr(bus_addr);
  assign wr_ok = bus_wr & sp.aligned;

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic          hit;
    logic [DW-1:0] route_r, en_r, type_r, pol_r, soft_r;

    assign hit = wr_ok && (sp.bank == 2'(b));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        route_r <= '0;
        en_r    <= '0;
        type_r  <= '0;
        pol_r   <= '0;
        soft_r  <= '0;
      end else if (hit) begin
        if (sp.base == OFS_ROUTE) route_r <= bus_wdata;
        if (sp.base == OFS_TYPE)  type_r  <= bus_wdata;
        if (sp.base == OFS_POL)   pol_r   <= bus_wdata;
        if (sp.base == OFS_SOFT)  soft_r  <= bus_wdata;
        if (sp.base == OFS_EN)         en_r <= bus_wdata;
        else if (sp.base == OFS_ENSET) en_r <= en_r | bus_wdata;
        else if (sp.base == OFS_ENCLR) en_r <= en_r & ~bus_wdata;
      end
    end

    assign route_q[b]   = route_r;
    assign en_q[b]      = en_r;
    assign type_q[b]    = type_r;
    assign pol_q[b]     = pol_r;
    assign soft_q[b]    = soft_r;
    assign ack_pulse[b] = (hit && sp.base == OFS_ACK) ? bus_wdata : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nopend_q <= '0;
      master_q <= '0;
    end else if (bus_wr) begin
      if (bus_addr == OFS_NOPEND) nopend_q <= bus_wdata;
      if (bus_addr == OFS_MASTER) master_q <= bus_wdata[1:0];
    end
  end
endmodule

// File: rtl/intc_detect.sv
module intc_detect #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] src_i,
  input  logic [W-1:0] pol_i,
  input  logic [W-1:0] typ_i,
  input  logic [W-1:0] soft_i,
  input  logic [W-1:0] ack_i,
  output logic [W-1:0] raw_o,
  output logic [W-1:0] edge_set_o,
  output logic [W-1:0] latch_o
);
  // Input after polarity, with the software request forcing it active.
  function automatic logic [W-1:0] active_view(input logic [W-1:0] s,
                                               input logic [W-1:0] p,
                                               input logic [W-1:0] f);
    return (s ^ p) | f;
  endfunction

  function automatic logic [W-1:0] rise(input logic [W-1:0] cur,
                                        input logic [W-1:0] prv);
    return cur & ~prv;
  endfunction

  logic [W-1:0] act, prev_q, latch_q;

  assign act        = active_view(src_i, pol_i, soft_i);
  assign edge_set_o = typ_i & rise(act, prev_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      latch_q <= '0;
    end else begin
      prev_q  <= act;
      latch_q <= (latch_q & ~ack_i) | edge_set_o;
    end
  end

  assign latch_o = latch_q;
  assign raw_o   = (typ_i & latch_q) | (~typ_i & act);
endmodule

// File: rtl/intc_prio.sv
module intc_prio #(
  parameter int N  = 64,
  parameter int DW = 32
) (
  input  logic [N-1:0]  req_i,
  input  logic [DW-1:0] none_i,
  output logic [DW-1:0] num_o
);
  function automatic logic [DW-1:0] lowest(input logic [N-1:0] v,
                                           input logic [DW-1:0] dflt);
    logic [DW-1:0] r;
    r = dflt;
    for (int i = N - 1; i >= 0; i--) begin
      if (v[i]) r = DW'(i);
    end
    return r;
  endfunction

  assign num_o = lowest(req_i, none_i);
endmodule

// File: rtl/pic_dual_bank.sv
module pic_dual_bank
  import intc_pkg::*;
#(
  parameter int N_SRC = 64,
  parameter int DW    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  src_in,
  input  logic              bus_wr,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              irq_out,
  output logic              fiq_out
);
  localparam int NB = N_SRC / DW;

  logic [NB-1:0][DW-1:0] route_q, en_q, type_q, pol_q, soft_q, ack_q;
  logic [DW-1:0]         nopend_q, pend_num;
  logic [1:0]            master_q;

  logic [N_SRC-1:0] route_f, en_f, raw_f, edge_set_f, latch_f;
  logic [N_SRC-1:0] irq_stat, fiq_stat;
  logic [NB-1:0][DW-1:0] irq_pk, fiq_pk, raw_pk;

  intc_regs #(.NB(NB), .DW(DW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .route_q   (route_q),
    .en_q      (en_q),
    .type_q    (type_q),
    .pol_q     (pol_q),
    .soft_q    (soft_q),
    .ack_pulse (ack_q),
    .nopend_q  (nopend_q),
    .master_q  (master_q)
  );

  assign route_f = route_q;
  assign en_f    = en_q;

  for (genvar b = 0; b < NB; b++) begin : g_det
    intc_detect #(.W(DW)) u_det (
      .clk        (clk),
      .rst_n      (rst_n),
      .src_i      (src_in[b*DW +: DW]),
      .pol_i      (pol_q[b]),
      .typ_i      (type_q[b]),
      .soft_i     (soft_q[b]),
      .ack_i      (ack_q[b]),
      .raw_o      (raw_f[b*DW +: DW]),
      .edge_set_o (edge_set_f[b*DW +: DW]),
      .latch_o    (latch_f[b*DW +: DW])
    );
  end

  assign irq_stat = raw_f & en_f & ~route_f;
  assign fiq_stat = raw_f & en_f & route_f;
  assign irq_pk   = irq_stat;
  assign fiq_pk   = fiq_stat;
  assign raw_pk   = raw_f;

  assign irq_out = master_q[0] & (|irq_stat);
  assign fiq_out = master_q[1] & (|fiq_stat);

  intc_prio #(.N(N_SRC), .DW(DW)) u_prio (
    .req_i  (irq_stat),
    .none_i (nopend_q),
    .num_o  (pend_num)
  );

  // Read path: each bank contributes its word, OR-chained.
  addr_split_t   sp;
  logic [DW-1:0] rd_chain [0:NB];

  assign sp          = split_addr(bus_addr);
  assign rd_chain[0] = '0;

  for (genvar b = 0; b < NB; b++) begin : g_rd
    logic [DW-1:0] rd_b;
    always_comb begin
      rd_b = '0;
      if (sp.aligned && sp.bank == 2'(b)) begin
        case (sp.base)
          OFS_ROUTE: rd_b = route_q[b];
          OFS_EN:    rd_b = en_q[b];
          OFS_TYPE:  rd_b = type_q[b];
          OFS_POL:   rd_b = pol_q[b];
          OFS_IRQST: rd_b = irq_pk[b];
          OFS_FIQST: rd_b = fiq_pk[b];
          OFS_RAW:   rd_b = raw_pk[b];
          OFS_SOFT:  rd_b = soft_q[b];
          default:   rd_b = '0;
        endcase
      end
    end
    assign rd_chain[b+1] = rd_chain[b] | rd_b;
  end

  always_comb begin
    if (bus_addr == OFS_NOPEND)      bus_rdata = nopend_q;
    else if (bus_addr == OFS_MASTER) bus_rdata = DW'(master_q);
    else if (bus_addr == OFS_PNUM)   bus_rdata = pend_num;
    else                             bus_rdata = rd_chain[NB];
  end
endmodule

// File: rtl/pic_checker.sv
module pic_checker
  import intc_pkg::*;
#(
  parameter int N_SRC = 64,
  parameter int DW    = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [REG_AW-1:0] bus_addr,
  input logic [DW-1:0]     bus_wdata,
  input logic              irq_out,
  input logic              fiq_out,
  input logic [1:0]        master_q,
  input logic [N_SRC-1:0]  en_f,
  input logic [N_SRC-1:0]  edge_set_f,
  input logic [N_SRC-1:0]  latch_f,
  input logic [N_SRC-1:0]  irq_stat,
  input logic [N_SRC-1:0]  fiq_stat,
  input logic [DW-1:0]     nopend_q,
  input logic [DW-1:0]     pend_num
);
  AST_IRQ_MASTER_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    !master_q[0] |-> !irq_out); // R9
  AST_FIQ_MASTER_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    !master_q[1] |-> !fiq_out); // R9
  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (irq_stat != '0)); // R8
  AST_FIQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_out |-> (fiq_stat != '0)); // R8
  AST_ENSET_ORS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_ENSET) |=>
      (en_f[DW-1:0] == ($past(en_f[DW-1:0]) | $past(bus_wdata)))); // R3
  AST_ENCLR_ANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_ENCLR) |=>
      (en_f[DW-1:0] == ($past(en_f[DW-1:0]) & ~$past(bus_wdata)))); // R3
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_ACK && bus_wdata[0] && !edge_set_f[0]) |=> !latch_f[0]); // R6
  AST_EDGE_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    edge_set_f[0] |=> latch_f[0]); // R11
  AST_NOPEND_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_stat == '0) |-> (pend_num == nopend_q)); // R10
endmodule

bind pic_dual_bank pic_checker #(.N_SRC(N_SRC), .DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .irq_out    (irq_out),
  .fiq_out    (fiq_out),
  .master_q   (master_q),
  .en_f       (en_f),
  .edge_set_f (edge_set_f),
  .latch_f    (latch_f),
  .irq_stat   (irq_stat),
  .fiq_stat   (fiq_stat),
  .nopend_q   (nopend_q),
  .pend_num   (pend_num)
);

// File: tb/tb_pic_dual_bank.sv
`timescale 1ns/1ps
module tb_pic_dual_bank;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [63:0] src_in = '0;
  logic        bus_wr = 0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_out, fiq_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  pic_dual_bank dut (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_out(irq_out), .fiq_out(fiq_out)
  );

  // ---------------- behavioural reference model ----------------
  bit m_route[64], m_en[64], m_type[64], m_pol[64], m_soft[64];
  bit m_latch[64], m_prev[64];
  bit [1:0]  m_master;
  bit [31:0] m_nopend;

  function automatic bit m_act(int n);
    return (src_in[n] ^ m_pol[n]) | m_soft[n];
  endfunction
  function automatic bit m_raw(int n);
    return m_type[n] ? m_latch[n] : m_act(n);
  endfunction
  function automatic bit m_irq(int n);
    return m_raw(n) && m_en[n] && !m_route[n];
  endfunction
  function automatic bit m_fiq(int n);
    return m_raw(n) && m_en[n] && m_route[n];
  endfunction
  function automatic logic [31:0] m_pnum();
    for (int n = 0; n < 64; n++) if (m_irq(n)) return n;
    return m_nopend;
  endfunction

  function automatic logic [31:0] m_read(logic [7:0] a);
    logic [31:0] r;
    int k, base;
    r = 0;
    if (a[1:0] != 0) return 0;
    if (a == 8'h60) return m_nopend;
    if (a == 8'h64) return {30'd0, m_master};
    if (a == 8'hD0) return m_pnum();
    k = a[3:2];
    base = a & 8'hF0;
    if (k > 1) return 0;
    for (int i = 0; i < 32; i++) begin
      int n;
      n = k * 32 + i;
      case (base)
        'h00: r[i] = m_route[n];
        'h10: r[i] = m_en[n];
        'h40: r[i] = m_type[n];
        'h50: r[i] = m_pol[n];
        'h80: r[i] = m_irq(n);
        'h90: r[i] = m_fiq(n);
        'hA0: r[i] = m_raw(n);
        'hC0: r[i] = m_soft[n];
        default: r[i] = 0;
      endcase
    end
    return r;
  endfunction

  task automatic m_write(logic [7:0] a, logic [31:0] d);
    int k, base;
    if (a == 8'h60) begin m_nopend = d; return; end
    if (a == 8'h64) begin m_master = d[1:0]; return; end
    if (a[1:0] != 0) return;
    k = a[3:2];
    base = a & 8'hF0;
    if (k > 1) return;
    for (int i = 0; i < 32; i++) begin
      int n;
      n = k * 32 + i;
      case (base)
        'h00: m_route[n] = d[i];
        'h10: m_en[n] = d[i];
        'h20: if (d[i]) m_en[n] = 0;
        'h30: if (d[i]) m_en[n] = 1;
        'h40: m_type[n] = d[i];
        'h50: m_pol[n] = d[i];
        'hC0: m_soft[n] = d[i];
        default: ;
      endcase
    end
  endtask

  always @(posedge clk) begin
    bit nl[64];
    bit np[64];
    if (!rst_n) begin
      for (int n = 0; n < 64; n++) begin
        m_route[n] = 0; m_en[n] = 0; m_type[n] = 0; m_pol[n] = 0;
        m_soft[n] = 0; m_latch[n] = 0; m_prev[n] = 0;
      end
      m_master = 0;
      m_nopend = 0;
    end else begin
      for (int n = 0; n < 64; n++) begin
        bit a;
        a = m_act(n);
        nl[n] = m_latch[n];
        if (bus_wr && bus_addr == 8'(8'hB0 + 4 * (n / 32)) && bus_wdata[n % 32]) nl[n] = 0;
        if (m_type[n] && a && !m_prev[n]) nl[n] = 1;
        np[n] = a;
      end
      for (int n = 0; n < 64; n++) begin
        m_latch[n] = nl[n];
        m_prev[n]  = np[n];
      end
      if (bus_wr) m_write(bus_addr, bus_wdata);
    end
  end

  // Per-clock comparison of the pins against the model.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit ei, ef;
      ei = 0; ef = 0;
      for (int n = 0; n < 64; n++) begin
        ei |= m_irq(n);
        ef |= m_fiq(n);
      end
      ei &= m_master[0];
      ef &= m_master[1];
      checks += 3;
      if (irq_out !== ei) begin
        fails++; $display("FAIL R9 irq_out act=%0b exp=%0b t=%0t", irq_out, ei, $time);
      end
      if (fiq_out !== ef) begin
        fails++; $display("FAIL R9 fiq_out act=%0b exp=%0b t=%0t", fiq_out, ef, $time);
      end
      if (bus_rdata !== m_read(bus_addr)) begin
        fails++; $display("FAIL R2 rdata@%h act=%h exp=%h t=%0t", bus_addr, bus_rdata,
                          m_read(bus_addr), $time);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    step();
    bus_wr = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] v);
    bus_addr = a;
    @(negedge clk);
    v = bus_rdata;
    step();
  endtask

  task automatic rd_chk(string tag, logic [7:0] a, logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic pins_chk(string tag, bit ei, bit ef);
    @(negedge clk);
    chk({tag, " irq"}, {31'd0, irq_out}, {31'd0, ei});
    chk({tag, " fiq"}, {31'd0, fiq_out}, {31'd0, ef});
    step();
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    step();

    // R1 reset state
    rd_chk("R1 route0", 8'h00, 0);
    rd_chk("R1 en1", 8'h14, 0);
    rd_chk("R1 type0", 8'h40, 0);
    rd_chk("R1 pol1", 8'h54, 0);
    rd_chk("R1 soft0", 8'hC0, 0);
    rd_chk("R1 master", 8'h64, 0);
    rd_chk("R1 nopend", 8'h60, 0);
    pins_chk("R1 pins", 0, 0);

    // R4 level source 3, direct enable write (R3)
    wr(8'h10, 32'h8);
    wr(8'h64, 32'h1);
    src_in[3] = 1;
    rd_chk("R4 raw0 level high", 8'hA0, 32'h8);
    rd_chk("R8 irqst0", 8'h80, 32'h8);
    rd_chk("R10 pnum 3", 8'hD0, 3);
    pins_chk("R9 irq on", 1, 0);
    src_in[3] = 0;
    rd_chk("R4 raw0 level low", 8'hA0, 0);

    // R2/R4 active-low source 37 in bank 1
    wr(8'h54, 32'h20);
    rd_chk("R4 raw1 active low", 8'hA4, 32'h20);
    wr(8'h34, 32'h20);
    rd_chk("R3 enset1", 8'h14, 32'h20);
    rd_chk("R3 en0 untouched", 8'h10, 32'h8);
    rd_chk("R2 pnum 37", 8'hD0, 37);
    wr(8'h24, 32'h20);
    rd_chk("R3 enclr1", 8'h14, 0);
    src_in[37] = 1;
    rd_chk("R4 raw1 inactive", 8'hA4, 0);

    // R5 edge source 7
    wr(8'h40, 32'h80);
    wr(8'h30, 32'h80);
    rd_chk("R3 enset0 keeps bit3", 8'h10, 32'h88);
    src_in[7] = 1;
    step();
    src_in[7] = 0;
    step();
    rd_chk("R5 latched after input low", 8'hA0, 32'h80);
    wr(8'hB0, 32'h80);
    rd_chk("R6 ack clears", 8'hA0, 0);
    src_in[7] = 1;
    step();
    wr(8'hB0, 32'h80);
    rd_chk("R5 held high no retrigger", 8'hA0, 0);
    src_in[3] = 1;
    wr(8'hB0, 32'h8);
    rd_chk("R6 ack level no effect", 8'hA0, 32'h8);
    src_in[3] = 0;

    // R11 edge and ack on the same clock edge
    src_in[7] = 0;
    step();
    src_in[7] = 1;
    wr(8'hB0, 32'h80);
    rd_chk("R11 set wins", 8'hA0, 32'h80);
    wr(8'hB0, 32'h80);
    rd_chk("R11 later ack clears", 8'hA0, 0);

    // R7 software request on source 32
    wr(8'hC4, 32'h1);
    wr(8'h34, 32'h1);
    rd_chk("R7 soft raw1", 8'hA4, 32'h1);
    rd_chk("R7 soft irqst1", 8'h84, 32'h1);
    rd_chk("R10 pnum 32", 8'hD0, 32);
    wr(8'hC4, 32'h0);
    rd_chk("R7 soft removed", 8'hA4, 0);

    // R8 routing, R9 master gating
    wr(8'h04, 32'h1);
    wr(8'hC4, 32'h1);
    rd_chk("R8 fiqst1", 8'h94, 32'h1);
    rd_chk("R8 irqst1 empty", 8'h84, 0);
    pins_chk("R9 fiq gated", 0, 0);
    wr(8'h64, 32'h3);
    pins_chk("R9 fiq on", 0, 1);
    src_in[3] = 1;
    wr(8'h64, 32'h2);
    pins_chk("R9 irq gated", 0, 1);
    rd_chk("R9 irqst0 ungated", 8'h80, 32'h8);

    // R10 none code
    src_in[3] = 0;
    wr(8'hC4, 32'h0);
    wr(8'h60, 32'h3F);
    rd_chk("R10 none code", 8'hD0, 32'h3F);

    // R2 top source 63, then lower source wins (R10)
    wr(8'h34, 32'h8000_0000);
    src_in[63] = 1;
    rd_chk("R2 raw1 bit31", 8'hA4, 32'h8000_0000);
    rd_chk("R2 pnum 63", 8'hD0, 63);
    src_in[3] = 1;
    rd_chk("R10 lowest wins", 8'hD0, 3);
    wr(8'h64, 32'h1);
    pins_chk("R9 irq back", 1, 0);

    // unmapped read
    rd_chk("R2 unmapped", 8'h68, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule